// File: doc/BRIEF.md
# Transparent Translation Address Matcher

This block sits in front of a page-table walker and decides, for every memory access, whether the logical address lies inside a transparently mapped window. A hit means the access needs no table walk. The physical address is the logical address, and the permissions and cache mode come straight from the window register that matched. Four window registers are held: two serve instruction fetches and two serve data accesses. The access class selects which pair is examined, and within a pair the lower-numbered register takes priority.

Each window compares the top byte of the address against a base byte. A per-bit ignore mask is applied to that compare, and the match can optionally be qualified by the privilege level of the access. A lookup can also be issued as a test probe, which records the result in a small status register. Software-visible configuration is a plain indexed write port and a combinational indexed read port.

Top module: `ttw_matcher`

## Requirements
- R1: A window register takes part in matching only when its enable bit (bit 15) is 1. A disabled register never produces a hit, whatever its other fields hold.
- R2: The privilege field in bits [14:13] selects the mode qualification. Code 00 matches only user accesses (`req_super`=0). Code 01 matches only supervisor accesses. Codes 10 and 11 match at either level.
- R3: The base byte is held in bits [31:24] and the ignore mask in bits [23:16]. The address matches when `req_addr[31:24]` equals the base in every bit position whose mask bit is 0. Mask bits set to 1 exclude that position from the compare.
- R4: A hit always grants read and execute. It grants write only when the write-protect bit (bit 2) of the matching register is 0. A miss grants nothing.
- R5: Instruction fetches (`req_code`=1) are checked against registers 0 and 1, and data accesses against registers 2 and 3. If both registers of the pair match, the lower index wins. `rsp_slot` gives the winner's position within the pair (0 or 1), and `rsp_cmode` carries bits [6:5] of the winner. Both are 0 on a miss.
- R6: On a hit `rsp_paddr` equals the request address. On a miss it is 0.
- R7: A probe lookup (`req_probe`=1) that hits sets `probe_status` to 3: transparent flag in bit 1 and resident flag in bit 0, with no other bit set. A probe that misses sets it to 0.
- R8: A store that hits a write-protected window raises `rsp_wp_fault` together with the response, for that single cycle, and grants no write. Loads, misses and stores to writable windows never raise it.
- R9: Reading register n through `cfg_ridx` returns exactly the 32-bit value last written to it. Reset clears all four registers to zero, which leaves them disabled.
- R10: The response to a request presented at a clock edge appears at that edge's outputs, with `rsp_valid` high for exactly one cycle. A register write at the same edge as a lookup does not affect that lookup.
- R11: A lookup that is not a probe leaves `probe_status` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Window register write strobe |
| cfg_idx | input | 2 | Register index to write |
| cfg_wdata | input | 32 | Register write value |
| cfg_ridx | input | 2 | Register index to read |
| cfg_rdata | output | 32 | Register read value (combinational) |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 32 | Logical address |
| req_code | input | 1 | 1 = instruction fetch, 0 = data access |
| req_super | input | 1 | 1 = supervisor access |
| req_store | input | 1 | 1 = store access |
| req_probe | input | 1 | 1 = test probe lookup |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | A transparent window matched |
| rsp_read | output | 1 | Read granted |
| rsp_exec | output | 1 | Execute granted |
| rsp_write | output | 1 | Write granted |
| rsp_wp_fault | output | 1 | Store hit a write-protected window |
| rsp_paddr | output | 32 | Physical address |
| rsp_cmode | output | 2 | Cache mode of the matching window |
| rsp_slot | output | 1 | Winning register within the selected pair |
| probe_status | output | 32 | Test probe status |

## Verification
Each lookup result, including the fault pulse and the probe status, is due at the first rising edge after the request is driven. The bench drives on the falling edge and samples 1 ns after the following rising edge. It then samples once more after the next edge to confirm that the fault and valid flags have dropped. The read port is combinational, so it is sampled 1 ns after the index changes. One directed case writes a register at the same edge as a lookup and expects the old contents to decide that lookup.

// File: rtl/ttw_pkg.sv
package ttw_pkg;

    localparam int WORD_W       = 32;
    localparam int FIELD_W      = 8;
    localparam int BASE_LSB     = 24;
    localparam int MASK_LSB     = 16;
    localparam int EN_BIT       = 15;
    localparam int PRIV_LSB     = 13;
    localparam int CMODE_LSB    = 5;
    localparam int WP_BIT       = 2;
    localparam int ST_RES_BIT   = 0;
    localparam int ST_TRN_BIT   = 1;

    typedef enum logic [1:0] {
        PRIV_USER_ONLY  = 2'b00,
        PRIV_SUPER_ONLY = 2'b01,
        PRIV_EITHER_A   = 2'b10,
        PRIV_EITHER_B   = 2'b11
    } priv_mode_e;

    typedef struct packed {
        logic       hit;
        logic       rd;
        logic       ex;
        logic       wr;
        logic       fault;
        logic [1:0] cmode;
    } ttw_grant_t;

    function automatic logic priv_ok(input logic [1:0] code, input logic is_super);
        logic ok;
        case (priv_mode_e'(code))
            PRIV_USER_ONLY:  ok = !is_super;
            PRIV_SUPER_ONLY: ok = is_super;
            default:         ok = 1'b1;
        endcase
        return ok;
    endfunction

    function automatic logic masked_eq(input logic [FIELD_W-1:0] a,
                                       input logic [FIELD_W-1:0] b,
                                       input logic [FIELD_W-1:0] ignore);
        return ((a ^ b) & ~ignore) == '0;
    endfunction

endpackage

// File: rtl/ttw_regfile.sv
module ttw_regfile #(
    parameter int NREG = 4,
    parameter int DW   = 32,
    localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [IW-1:0]            widx,
    input  logic [DW-1:0]            wdata,
    output logic [NREG-1:0][DW-1:0]  words
);

    logic [NREG-1:0][DW-1:0] store_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
        end else if (we) begin
            store_q[widx] <= wdata;
        end
    end

    assign words = store_q;

    AST_REG_READBACK: assert property (@(posedge clk) disable iff (rst)
        we |=> store_q[$past(widx)] == $past(wdata)); // R9

endmodule

// File: rtl/ttw_window_cmp.sv
module ttw_window_cmp
    import ttw_pkg::*;
(
    input  logic [FIELD_W-1:0] base,
    input  logic [FIELD_W-1:0] ignore,
    input  logic               enable,
    input  logic [1:0]         priv,
    input  logic [FIELD_W-1:0] addr_hi,
    input  logic               is_super,
    output logic               match
);

    logic addr_ok;
    logic mode_ok;

    always_comb begin
        addr_ok = masked_eq(addr_hi, base, ignore);
        mode_ok = priv_ok(priv, is_super);
        match   = enable && addr_ok && mode_ok;
    end

endmodule

// File: rtl/ttw_prio_sel.sv
module ttw_prio_sel #(
    parameter int N   = 2,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/ttw_matcher.sv
module ttw_matcher
    import ttw_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int WIN_PER_SIDE = 2,
    localparam int NREG        = 2 * WIN_PER_SIDE,
    localparam int RIDX_W      = $clog2(NREG),
    localparam int SLOT_W      = (WIN_PER_SIDE > 1) ? $clog2(WIN_PER_SIDE) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [RIDX_W-1:0]   cfg_idx,
    input  logic [WORD_W-1:0]   cfg_wdata,
    input  logic [RIDX_W-1:0]   cfg_ridx,
    output logic [WORD_W-1:0]   cfg_rdata,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_code,
    input  logic                req_super,
    input  logic                req_store,
    input  logic                req_probe,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic                rsp_read,
    output logic                rsp_exec,
    output logic                rsp_write,
    output logic                rsp_wp_fault,
    output logic [ADDR_W-1:0]   rsp_paddr,
    output logic [1:0]          rsp_cmode,
    output logic [SLOT_W-1:0]   rsp_slot,
    output logic [WORD_W-1:0]   probe_status
);

    logic [NREG-1:0][WORD_W-1:0] words;
    logic [NREG-1:0]             win_match;
    logic [WIN_PER_SIDE-1:0]     side_match;
    logic                        found;
    logic [SLOT_W-1:0]           slot;
    logic [RIDX_W-1:0]           win_idx;
    logic                        win_wp;
    logic [1:0]                  win_cmode;
    ttw_grant_t                  grant_d, grant_q;
    logic                        valid_q;
    logic [ADDR_W-1:0]           paddr_d, paddr_q;
    logic [SLOT_W-1:0]           slot_q;
    logic [1:0]                  status_q;

    // configuration storage
    ttw_regfile #(.NREG(NREG), .DW(WORD_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .widx  (cfg_idx),
        .wdata (cfg_wdata),
        .words (words)
    );

    assign cfg_rdata = words[cfg_ridx];

    // one comparator per window register
    for (genvar g = 0; g < NREG; g++) begin : g_win
        ttw_window_cmp u_cmp (
            .base     (words[g][BASE_LSB +: FIELD_W]),
            .ignore   (words[g][MASK_LSB +: FIELD_W]),
            .enable   (words[g][EN_BIT]),
            .priv     (words[g][PRIV_LSB +: 2]),
            .addr_hi  (req_addr[ADDR_W-1 -: FIELD_W]),
            .is_super (req_super),
            .match    (win_match[g])
        );
    end

    // the access class picks the instruction or data pair
    assign side_match = req_code ? win_match[WIN_PER_SIDE-1:0]
                                 : win_match[NREG-1:WIN_PER_SIDE];

    ttw_prio_sel #(.N(WIN_PER_SIDE)) u_prio (
        .req   (side_match),
        .found (found),
        .idx   (slot)
    );

    always_comb begin
        win_idx   = RIDX_W'(slot) + (req_code ? RIDX_W'(0) : RIDX_W'(WIN_PER_SIDE));
        win_wp    = words[win_idx][WP_BIT];
        win_cmode = words[win_idx][CMODE_LSB +: 2];

        grant_d       = '0;
        grant_d.hit   = req_valid && found;
        grant_d.rd    = grant_d.hit;
        grant_d.ex    = grant_d.hit;
        grant_d.wr    = grant_d.hit && !win_wp;
        grant_d.fault = grant_d.hit && win_wp && req_store;
        grant_d.cmode = grant_d.hit ? win_cmode : 2'b00;
        paddr_d       = grant_d.hit ? req_addr : '0;
    end

    // registered response
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            grant_q <= '0;
            paddr_q <= '0;
            slot_q  <= '0;
        end else begin
            valid_q <= req_valid;
            grant_q <= grant_d;
            paddr_q <= paddr_d;
            slot_q  <= grant_d.hit ? slot : '0;
        end
    end

    // probe status: transparent + resident on a probe hit, clear on a probe miss
    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= 2'b00;
        end else if (req_valid && req_probe) begin
            status_q[ST_RES_BIT] <= grant_d.hit;
            status_q[ST_TRN_BIT] <= grant_d.hit;
        end
    end

    assign rsp_valid    = valid_q;
    assign rsp_hit      = grant_q.hit;
    assign rsp_read     = grant_q.rd;
    assign rsp_exec     = grant_q.ex;
    assign rsp_write    = grant_q.wr;
    assign rsp_wp_fault = grant_q.fault;
    assign rsp_paddr    = paddr_q;
    assign rsp_cmode    = grant_q.cmode;
    assign rsp_slot     = slot_q;
    assign probe_status = {{(WORD_W-2){1'b0}}, status_q};

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R10
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid && !rsp_hit); // R10
    AST_HIT_GRANTS_RX: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_read && rsp_exec); // R4
    AST_WRITE_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        rsp_write |-> rsp_hit); // R4
    AST_PADDR_IDENTITY: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_paddr == $past(req_addr)); // R6
    AST_FAULT_ON_STORE: assert property (@(posedge clk) disable iff (rst)
        rsp_wp_fault |-> $past(req_store) && rsp_hit && !rsp_write); // R8
    AST_STATUS_ONLY_PROBE: assert property (@(posedge clk) disable iff (rst)
        !$stable(status_q) |-> $past(req_valid && req_probe)); // R11
    AST_STATUS_CODES: assert property (@(posedge clk) disable iff (rst)
        status_q[ST_RES_BIT] == status_q[ST_TRN_BIT]); // R7

endmodule

// File: tb/test_ttw_matcher.sv
`timescale 1ns/1ps
module test_ttw_matcher;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [1:0]  cfg_ridx = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_code = 1'b0;
    logic        req_super = 1'b0;
    logic        req_store = 1'b0;
    logic        req_probe = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_read, rsp_exec, rsp_write, rsp_wp_fault;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_cmode;
    logic [0:0]  rsp_slot;
    logic [31:0] probe_status;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [31:0] model [4];

    always #4 clk = ~clk;

    ttw_matcher i_ttw_matcher (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .cfg_ridx(cfg_ridx), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_code(req_code),
        .req_super(req_super), .req_store(req_store), .req_probe(req_probe),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_read(rsp_read),
        .rsp_exec(rsp_exec), .rsp_write(rsp_write), .rsp_wp_fault(rsp_wp_fault),
        .rsp_paddr(rsp_paddr), .rsp_cmode(rsp_cmode), .rsp_slot(rsp_slot),
        .probe_status(probe_status)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // {hit, rd, ex, wr, fault, cmode[1:0], slot, paddr[31:0]}
    function automatic logic [39:0] expect_rsp(input logic [31:0] addr, input bit code,
                                               input bit sup, input bit store);
        for (int j = 0; j < 2; j++) begin
            logic [31:0] r;
            bit mode_ok;
            r = model[(code ? 0 : 2) + j];
            mode_ok = (r[14:13] == 2'b00) ? !sup : (r[14:13] == 2'b01) ? sup : 1'b1;
            if (r[15] && mode_ok && (((addr[31:24] ^ r[31:24]) & ~r[23:16]) == 8'h00))
                return {1'b1, 1'b1, 1'b1, !r[2], r[2] && store, r[6:5], j[0], addr};
        end
        return 40'h0;
    endfunction

    function automatic logic [39:0] actual_rsp();
        return {rsp_hit, rsp_read, rsp_exec, rsp_write, rsp_wp_fault, rsp_cmode,
                rsp_slot, rsp_paddr};
    endfunction

    task automatic wr_reg(input logic [1:0] idx, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = val;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        model[idx] = val;
    endtask

    task automatic rd_check(input logic [1:0] idx, input string req);
        cfg_ridx = idx;
        #1;
        check(cfg_rdata === model[idx], req, {32'h0, cfg_rdata}, {32'h0, model[idx]});
    endtask

    task automatic lookup(input logic [31:0] addr, input bit code, input bit sup,
                          input bit store, input bit probe, input string req);
        logic [39:0] exp;
        exp = expect_rsp(addr, code, sup, store);
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_code = code;
        req_super = sup; req_store = store; req_probe = probe;
        @(posedge clk); #1;
        req_valid = 1'b0; req_probe = 1'b0; req_store = 1'b0;
        check(rsp_valid === 1'b1 && actual_rsp() === exp, req,
              {23'h0, rsp_valid, actual_rsp()}, {23'h0, 1'b1, exp});
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) model[i] = 32'h0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R9: reset clears all registers
        for (int i = 0; i < 4; i++) rd_check(2'(i), "R9 reset value");
        check(probe_status === 32'h0, "R7 reset status", {32'h0, probe_status}, 64'h0);
        // R1: zeroed register (base 0, mask 0) would match address 0 if enabled
        lookup(32'h00000000, 1'b1, 1'b0, 1'b0, 1'b0, "R1 disabled never hits");
        @(posedge clk); #1;
        check(rsp_valid === 1'b0, "R10 valid single cycle", {63'h0, rsp_valid}, 64'h0);

        // R3 / R6: base 0x40, ignore 0x0F, either privilege, cmode 01, writable
        wr_reg(2'd0, 32'h400FC020);
        rd_check(2'd0, "R9 readback");
        lookup(32'h4A123456, 1'b1, 1'b0, 1'b0, 1'b0, "R3 masked match / R6 identity");
        lookup(32'h5A123456, 1'b1, 1'b0, 1'b0, 1'b0, "R3 unmasked bit differs");
        lookup(32'h4A123456, 1'b0, 1'b0, 1'b0, 1'b0, "R5 data side ignores code regs");

        // R2: user-only then supervisor-only in register 1
        wr_reg(2'd1, 32'h80008000);
        lookup(32'h80000010, 1'b1, 1'b0, 1'b0, 1'b0, "R2 user-only user access");
        lookup(32'h80000010, 1'b1, 1'b1, 1'b0, 1'b0, "R2 user-only super access");
        wr_reg(2'd1, 32'h8000A000);
        lookup(32'h80000010, 1'b1, 1'b1, 1'b0, 1'b0, "R2 super-only super access");
        lookup(32'h80000010, 1'b1, 1'b0, 1'b0, 1'b0, "R2 super-only user access");

        // R5 / R4 / R8: data pair, both match, lower wins (write protected)
        wr_reg(2'd2, 32'h12FFE044);
        wr_reg(2'd3, 32'h1200E060);
        lookup(32'h12345678, 1'b0, 1'b0, 1'b0, 1'b0, "R5 priority / R4 no write on wp");
        lookup(32'h12345678, 1'b0, 1'b1, 1'b1, 1'b0, "R8 store to wp window faults");
        @(posedge clk); #1;
        check(rsp_wp_fault === 1'b0, "R8 fault is one cycle", {63'h0, rsp_wp_fault}, 64'h0);
        lookup(32'h12345678, 1'b1, 1'b0, 1'b1, 1'b0, "R8 code side miss no fault");

        // R1: disabling register 2 lets register 3 win
        wr_reg(2'd2, 32'h12FF6044);
        rd_check(2'd2, "R9 readback after disable");
        lookup(32'h12345678, 1'b0, 1'b0, 1'b1, 1'b0, "R1 disabled skipped / R4 write grant");

        // R7 / R11: probe status
        lookup(32'h12000000, 1'b0, 1'b0, 1'b0, 1'b1, "R7 probe hit");
        check(probe_status === 32'h3, "R7 probe hit status", {32'h0, probe_status}, 64'h3);
        lookup(32'hEE000000, 1'b0, 1'b0, 1'b0, 1'b0, "R11 plain miss");
        check(probe_status === 32'h3, "R11 status unchanged", {32'h0, probe_status}, 64'h3);
        lookup(32'hEE000000, 1'b0, 1'b0, 1'b0, 1'b1, "R7 probe miss");
        check(probe_status === 32'h0, "R7 probe miss status", {32'h0, probe_status}, 64'h0);

        // R10: write and lookup at the same edge, lookup sees old contents
        begin
            logic [39:0] exp_old;
            exp_old = expect_rsp(32'h12ABCDEF, 1'b0, 1'b0, 1'b0);
            @(negedge clk);
            cfg_we = 1'b1; cfg_idx = 2'd3; cfg_wdata = 32'h00000000;
            req_valid = 1'b1; req_addr = 32'h12ABCDEF; req_code = 1'b0;
            req_super = 1'b0; req_store = 1'b0; req_probe = 1'b0;
            @(posedge clk); #1;
            cfg_we = 1'b0; req_valid = 1'b0;
            model[3] = 32'h0;
            check(actual_rsp() === exp_old, "R10 same-edge write not seen",
                  {24'h0, actual_rsp()}, {24'h0, exp_old});
        end
        lookup(32'h12ABCDEF, 1'b0, 1'b0, 1'b0, 1'b0, "R10 write seen next lookup");

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [31:0] addr;
            logic [1:0]  ri;
            if ($urandom_range(0, 3) == 0) begin
                logic [31:0] v;
                v = $urandom;
                if ($urandom_range(0, 3) != 0) v[15] = 1'b1;
                if ($urandom_range(0, 1) == 0) v[23:16] = v[23:16] & 8'h0F;
                wr_reg(2'($urandom_range(0, 3)), v);
            end
            ri   = 2'($urandom_range(0, 3));
            addr = $urandom;
            if ($urandom_range(0, 2) != 0)
                addr[31:24] = model[ri][31:24] ^ (8'($urandom) & model[ri][23:16]);
            lookup(addr, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                   $urandom_range(0, 1) == 1, 1'b0, "R2/R3/R4/R5/R6/R8 random");
            if (n % 50 == 0) rd_check(ri, "R9 random readback");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule